// File: doc/BRIEF.md
# Four-Plane Host Write Datapath

This block turns one byte written by the host into a 32-bit word for a frame buffer that is split into four planes of eight bits each. It sits between the host write port and the plane memories. The host byte passes through four stages in a fixed order. A barrel rotator comes first. A mode-dependent expander follows and builds the four plane bytes. A two-operand logic unit then combines that word with a held copy of the frame buffer. Last, a per-bit selector picks, bit by bit, between the new value and the held copy.

The held copy is a 32-bit latch. It captures all four plane bytes whenever the frame buffer is read. Software can therefore read a location, then write to it, to combine source and destination data, or copy screen data with no host data at all. The result is registered. It appears one cycle after the write strobe, together with a one-cycle valid flag and four per-plane write enables taken from a plane-enable input.

Top module: `vga_plane_writer`

## Requirements
- R1: After reset, wrValid is 0, wrData is 0 and wrByteEn is 0.
- R2: On every cycle with rdStrobe high, the latch captures fbRdData (plane p in bits 8p+7:8p), and later writes use the new value.
- R3: The host byte is rotated right by rotCount (0 to 7): rotated bit n = host bit (n+rotCount) mod 8. Rotation is applied to write mode 0 data and to the write mode 3 mask.
- R4: Write mode 0 (wrMode=00): plane byte p is eight copies of setRst[p] when setRstEn[p]=1, otherwise the rotated host byte.
- R5: Write mode 1 (wrMode=01): wrData equals the latch, whatever the host byte, the ALU function and the bit mask are.
- R6: Write mode 2 (wrMode=10): plane byte p is eight copies of host bit p, with no rotation.
- R7: Write mode 3 (wrMode=11): plane byte p is eight copies of setRst[p], and the effective mask is the rotated host byte ANDed with bitMask.
- R8: aluFn combines the mode word with the latch: 00 copy, 01 AND, 10 OR, 11 XOR.
- R9: In modes 0, 2 and 3, output bit n of every plane byte is the ALU result when effective mask bit n is 1, otherwise the latch bit.
- R10: wrValid is high for exactly the one cycle after each cycle with wrStrobe high, and wrByteEn then equals the planeEn sampled with the strobe.
- R11: With bitMask=0 and aluFn=00, modes 0 and 2 write the latch unchanged. Mode 3 does the same, because its effective mask is also 0. This emulates mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStrobe | input | 1 | Host write request |
| hostByte | input | 8 | Host write data |
| rdStrobe | input | 1 | Frame buffer read; loads the latch |
| fbRdData | input | 32 | Frame buffer read data, four plane bytes |
| rotCount | input | 3 | Right-rotate amount |
| wrMode | input | 2 | Write mode 0 to 3 |
| aluFn | input | 2 | Logic function |
| setRst | input | 4 | Per-plane fill bit |
| setRstEn | input | 4 | Per-plane fill enable for mode 0 |
| bitMask | input | 8 | Per-bit new/latch select |
| planeEn | input | 4 | Per-plane write enable request |
| wrData | output | 32 | Registered write word |
| wrByteEn | output | 4 | Registered per-plane write enables |
| wrValid | output | 1 | Write word valid, one cycle |

## Verification
The hardest case to reach from the ports is one where the latch differs from the data being written and every stage changes the result at once. The stimulus first performs a read with a distinctive pattern, so that every latch bit can be told apart from set/reset fills and from host bits. It then runs the writes of each mode against that latch, with partial masks and each logic function. In the mode 1 emulation case, a zero mask and the copy function must return the latch from every other mode. The latch is reloaded between groups, so that both a stale latch and a fresh one are observed.

// File: rtl/vga_wr_pkg.sv
package vga_wr_pkg;
  localparam int PLANES = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = PLANES * BYTE_W;
  localparam int ROT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ALU_COPY = 2'b00,
    ALU_AND  = 2'b01,
    ALU_OR   = 2'b10,
    ALU_XOR  = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    WM_HOST  = 2'b00,
    WM_LATCH = 2'b01,
    WM_COLOR = 2'b10,
    WM_FILL  = 2'b11
  } wr_mode_e;

  typedef struct packed {
    logic loadLatch;
    logic capture;
    logic allowFillEn;
    logic forceFill;
    logic replicate;
    logic hostMask;
    logic passLatch;
  } ctrl_t;
endpackage

// File: rtl/vga_wr_ctrl.sv
module vga_wr_ctrl
  import vga_wr_pkg::*;
(
  input  logic       wrStrobe,
  input  logic       rdStrobe,
  input  logic [1:0] wrMode,
  output ctrl_t      ctrl
);
  wr_mode_e mode;

  always_comb begin
    mode = wr_mode_e'(wrMode);
    ctrl = '0;
    ctrl.loadLatch = rdStrobe;
    ctrl.capture   = wrStrobe;
    unique case (mode)
      WM_HOST:  ctrl.allowFillEn = 1'b1;
      WM_LATCH: ctrl.passLatch   = 1'b1;
      WM_COLOR: ctrl.replicate   = 1'b1;
      WM_FILL: begin
        ctrl.forceFill = 1'b1;
        ctrl.hostMask  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vga_wr_datapath.sv
module vga_wr_datapath
  import vga_wr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_t               ctrl,
  input  logic [BYTE_W-1:0]   hostByte,
  input  logic [WORD_W-1:0]   fbRdData,
  input  logic [ROT_W-1:0]    rotCount,
  input  logic [1:0]          aluFn,
  input  logic [PLANES-1:0]   setRst,
  input  logic [PLANES-1:0]   setRstEn,
  input  logic [BYTE_W-1:0]   bitMask,
  input  logic [PLANES-1:0]   planeEn,
  output logic [WORD_W-1:0]   wrData,
  output logic [PLANES-1:0]   wrByteEn,
  output logic                wrValid,
  output logic [WORD_W-1:0]   latchQ
);
  logic [2*BYTE_W-1:0] rotWide;
  logic [BYTE_W-1:0]   rotByte;
  logic [BYTE_W-1:0]   effMask;
  logic [WORD_W-1:0]   mergedWord;
  alu_fn_e             fn;

  always_comb begin
    rotWide = {hostByte, hostByte} >> rotCount;
    rotByte = rotWide[BYTE_W-1:0];
    effMask = ctrl.hostMask ? (rotByte & bitMask) : bitMask;
    fn      = alu_fn_e'(aluFn);
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic [BYTE_W-1:0] modeByte;
    logic [BYTE_W-1:0] aluByte;
    logic [BYTE_W-1:0] latchByte;
    logic              useFill;

    always_comb begin
      latchByte = latchQ[p*BYTE_W +: BYTE_W];
      useFill   = ctrl.forceFill | (ctrl.allowFillEn & setRstEn[p]);
      if (ctrl.replicate)
        modeByte = {BYTE_W{hostByte[p]}};
      else if (useFill)
        modeByte = {BYTE_W{setRst[p]}};
      else
        modeByte = rotByte;

      unique case (fn)
        ALU_COPY: aluByte = modeByte;
        ALU_AND:  aluByte = modeByte & latchByte;
        ALU_OR:   aluByte = modeByte | latchByte;
        ALU_XOR:  aluByte = modeByte ^ latchByte;
      endcase

      if (ctrl.passLatch)
        mergedWord[p*BYTE_W +: BYTE_W] = latchByte;
      else
        mergedWord[p*BYTE_W +: BYTE_W] = (aluByte & effMask) | (latchByte & ~effMask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latchQ   <= '0;
      wrData   <= '0;
      wrByteEn <= '0;
      wrValid  <= 1'b0;
    end else begin
      if (ctrl.loadLatch) latchQ <= fbRdData;
      wrValid <= ctrl.capture;
      if (ctrl.capture) begin
        wrData   <= mergedWord;
        wrByteEn <= planeEn;
      end
    end
  end
endmodule

// File: rtl/vga_plane_writer.sv
module vga_plane_writer
  import vga_wr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStrobe,
  input  logic [7:0]  hostByte,
  input  logic        rdStrobe,
  input  logic [31:0] fbRdData,
  input  logic [2:0]  rotCount,
  input  logic [1:0]  wrMode,
  input  logic [1:0]  aluFn,
  input  logic [3:0]  setRst,
  input  logic [3:0]  setRstEn,
  input  logic [7:0]  bitMask,
  input  logic [3:0]  planeEn,
  output logic [31:0] wrData,
  output logic [3:0]  wrByteEn,
  output logic        wrValid
);
  ctrl_t             ctrl;
  logic [WORD_W-1:0] latchQ;

  vga_wr_ctrl u_ctrl (
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .wrMode(wrMode), .ctrl(ctrl)
  );

  vga_wr_datapath u_data (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .hostByte(hostByte),
    .fbRdData(fbRdData), .rotCount(rotCount), .aluFn(aluFn),
    .setRst(setRst), .setRstEn(setRstEn), .bitMask(bitMask),
    .planeEn(planeEn), .wrData(wrData), .wrByteEn(wrByteEn),
    .wrValid(wrValid), .latchQ(latchQ)
  );
endmodule

// File: rtl/vga_plane_writer_chk.sv
module vga_plane_writer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrStrobe,
  input logic        rdStrobe,
  input logic [31:0] fbRdData,
  input logic [1:0]  wrMode,
  input logic [1:0]  aluFn,
  input logic [7:0]  bitMask,
  input logic [3:0]  planeEn,
  input logic [31:0] wrData,
  input logic [3:0]  wrByteEn,
  input logic        wrValid,
  input logic [31:0] latchQ
);
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> wrValid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> !wrValid); // R10
  AST_ENABLES_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> wrByteEn == $past(planeEn)); // R10
  AST_LATCH_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> latchQ == $past(fbRdData)); // R2
  AST_MODE1_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && wrMode == 2'b01) |=> wrData == $past(latchQ)); // R5
  AST_ZERO_MASK_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && bitMask == 8'h00 && aluFn == 2'b00) |=> wrData == $past(latchQ)); // R11
endmodule

bind vga_plane_writer vga_plane_writer_chk u_chk (
  .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe),
  .fbRdData(fbRdData), .wrMode(wrMode), .aluFn(aluFn), .bitMask(bitMask),
  .planeEn(planeEn), .wrData(wrData), .wrByteEn(wrByteEn),
  .wrValid(wrValid), .latchQ(latchQ)
);

// File: tb/tb_vga_plane_writer.sv
module tb_vga_plane_writer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [7:0]  hostByte = '0;
  logic        rdStrobe = 1'b0;
  logic [31:0] fbRdData = '0;
  logic [2:0]  rotCount = '0;
  logic [1:0]  wrMode = '0;
  logic [1:0]  aluFn = '0;
  logic [3:0]  setRst = '0;
  logic [3:0]  setRstEn = '0;
  logic [7:0]  bitMask = 8'hFF;
  logic [3:0]  planeEn = 4'hF;
  logic [31:0] wrData;
  logic [3:0]  wrByteEn;
  logic        wrValid;

  int checks = 0;
  int fails = 0;
  logic [31:0] tbLatch = '0;
  logic [35:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  vga_plane_writer dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .hostByte(hostByte),
    .rdStrobe(rdStrobe), .fbRdData(fbRdData), .rotCount(rotCount),
    .wrMode(wrMode), .aluFn(aluFn), .setRst(setRst), .setRstEn(setRstEn),
    .bitMask(bitMask), .planeEn(planeEn), .wrData(wrData),
    .wrByteEn(wrByteEn), .wrValid(wrValid)
  );

  function automatic logic [31:0] model(input logic [7:0] h, input logic [2:0] rc,
      input logic [1:0] md, input logic [1:0] fn, input logic [3:0] sr,
      input logic [3:0] sre, input logic [7:0] bm, input logic [31:0] lat);
    logic [7:0] rot, msk;
    logic [31:0] res;
    logic mb, ab, lb;
    for (int n = 0; n < 8; n++) rot[n] = h[(n + rc) % 8];
    msk = (md == 2'd3) ? (rot & bm) : bm;
    for (int b = 0; b < 4; b++) begin
      for (int n = 0; n < 8; n++) begin
        lb = lat[b*8+n];
        case (md)
          2'd0: mb = sre[b] ? sr[b] : rot[n];
          2'd2: mb = h[b];
          default: mb = sr[b];
        endcase
        case (fn)
          2'd0: ab = mb;
          2'd1: ab = mb & lb;
          2'd2: ab = mb | lb;
          default: ab = mb ^ lb;
        endcase
        res[b*8+n] = (md == 2'd1) ? lb : (msk[n] ? ab : lb);
      end
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result is presented
  always @(negedge clk) begin
    if (rstN && wrValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R10 unexpected valid", {wrByteEn, wrData}, '0);
      end else begin
        logic [35:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check({wrByteEn, wrData} === e, t, {wrByteEn, wrData}, e);
      end
    end
  end

  task automatic doRead(input logic [31:0] d);
    rdStrobe = 1'b1;
    fbRdData = d;
    @(negedge clk);
    rdStrobe = 1'b0;
    tbLatch = d;
  endtask

  task automatic doWrite(input logic [7:0] h, input string tag);
    hostByte = h;
    wrStrobe = 1'b1;
    expQ.push_back({planeEn, model(h, rotCount, wrMode, aluFn, setRst, setRstEn, bitMask, tbLatch)});
    tagQ.push_back(tag);
    @(negedge clk);
    wrStrobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    check(1'b0, "watchdog", '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(wrValid == 1'b0 && wrData == '0 && wrByteEn == '0, "R1 reset",
          {wrByteEn, wrData}, '0);
    rstN = 1'b1;
    @(negedge clk);
    doRead(32'hA5C3_0F96);

    // R3: rotation, mode 0, copy, full mask
    wrMode = 2'd0; aluFn = 2'd0; bitMask = 8'hFF; setRstEn = 4'h0;
    for (int r = 0; r < 8; r++) begin
      rotCount = r[2:0];
      doWrite(8'hB4, "R3 rotate");
    end
    // R4: set/reset on selected planes
    rotCount = 3'd1; setRstEn = 4'b0101; setRst = 4'b0011;
    doWrite(8'h6E, "R4 mode0 fill");
    // R5: host, ALU and mask ignored
    wrMode = 2'd1; aluFn = 2'd3; bitMask = 8'h5A;
    doWrite(8'h00, "R5 mode1 a");
    doWrite(8'hFF, "R5 mode1 b");
    // R6: replicate, rotation ignored
    wrMode = 2'd2; aluFn = 2'd0; bitMask = 8'hFF; rotCount = 3'd3;
    doWrite(8'h5A, "R6 mode2");
    // R7: fill with host-derived mask
    wrMode = 2'd3; rotCount = 3'd2; bitMask = 8'h3C; setRst = 4'b1010;
    doWrite(8'hF0, "R7 mode3");
    // R8: each logic function
    wrMode = 2'd0; setRstEn = 4'h0; rotCount = 3'd0; bitMask = 8'hFF;
    for (int f = 0; f < 4; f++) begin
      aluFn = f[1:0];
      doWrite(8'h3C, "R8 alu");
    end
    // R9: partial mask
    aluFn = 2'd3; bitMask = 8'h0F;
    doWrite(8'hC6, "R9 mask");
    // R2: reload latch and copy it out
    doRead(32'h1234_ABCD);
    wrMode = 2'd1;
    doWrite(8'h77, "R2 latch reload");
    // R10: plane enables pass, valid only one cycle
    planeEn = 4'b1001; wrMode = 2'd2; aluFn = 2'd0; bitMask = 8'hFF;
    doWrite(8'h09, "R10 enables");
    check(wrValid == 1'b0, "R10 valid one cycle", {35'd0, wrValid}, '0);
    planeEn = 4'b0110;
    doWrite(8'h06, "R10 enables b");
    // R11: zero mask + copy from every other mode
    planeEn = 4'hF; bitMask = 8'h00; aluFn = 2'd0; setRstEn = 4'b1100; setRst = 4'hF;
    wrMode = 2'd0; doWrite(8'hE1, "R11 emu mode0");
    wrMode = 2'd2; doWrite(8'h0F, "R11 emu mode2");
    wrMode = 2'd3; doWrite(8'hFF, "R11 emu mode3");
    check(expQ.size() == 0, "R10 all results seen", 36'(expQ.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule